// File: doc/BRIEF.md
# Glitch-Free Power-of-Two System Clock Divider

This block takes a fast source clock and derives the system clock for the CPU and the synchronous peripherals. It divides by a power of two that software chooses with a 4-bit code. Software may write a new code at any time. The block holds the write back until the output period in progress has run to its end. It then restarts its divider count, so the output never carries a shortened or stretched pulse. The divider counter runs on the undivided source clock.

The block drives two timing outputs. `clk_out` is a registered square wave that is high for the first half of every divided period. `clk_en` is a one-source-cycle pulse in the first cycle of every divided period. Downstream logic may use either one. At divide-by-1 a register cannot toggle at the source rate, so `clk_out` stays high and `clk_en` is asserted on every cycle. In that mode `clk_en` is the timing reference.

A `busy` flag covers each rate change. It rises on the write and falls once the first full period at the new rate has been produced. That interval always contains exactly two rising output edges.

Top module: `sysclk_prescaler`

## Requirements
- R1: While `rst` is high, `clk_out`, `clk_en` and `busy` are all 0 after each clock edge. After reset is released, the divide ratio is 1.
- R2: Division codes 0 through 8 give divide ratios N = 2^code: 1, 2, 4, 8, 16, 32, 64, 128 and 256. In steady state, consecutive `clk_en` pulses are exactly N source cycles apart.
- R3: Division codes 9 through 15 are reserved. They give a divide ratio of 1.
- R4: In each divided period, `clk_out` is high for the first max(N/2, 1) source cycles, counted from the cycle in which `clk_en` is high. It is low for the rest of the period.
- R5: `clk_en` is high for exactly one source cycle per divided period. That cycle is the one in which `clk_out` has just risen. When N = 1, `clk_en` is high on every cycle and `clk_out` stays high.
- R6: A write never shortens or lengthens the period in progress: that period completes at the old length. The new code is applied only at a period boundary. A write that lands on a boundary cycle waits for the next boundary.
- R7: The first period after a new code is applied is a full period at the new ratio.
- R8: `busy` is high in the cycle after `div_wr` is sampled. It falls in the same cycle as the second `clk_en` pulse after the write. For a write sampled in the second cycle of an old period of length T1 ≥ 4, `busy` falls exactly (T1 − 1) + T2 source cycles after the write, where T2 is the new length.
- R9: A write that arrives while `busy` is high replaces any pending code. Only the last code written takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Undivided source clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 4 | Division code (0..8 gives 2^code; 9..15 give 1) |
| div_wr | input | 1 | Write strobe that captures `div_sel` |
| clk_out | output | 1 | Registered divided clock, high for the first half of each period |
| clk_en | output | 1 | One-cycle pulse at each divided rising edge |
| busy | output | 1 | High while a ratio change is pending or settling |

## Verification
Some properties are checked by assertions on every cycle:
- the divider count never passes the last count of the current ratio;
- `clk_en` appears only while `clk_out` is high, and accompanies every rising edge of `clk_out`;
- the active ratio changes only at a `clk_en` boundary and only from the armed phase;
- `busy` follows every write and falls only on a boundary.

Other behaviour needs directed scenarios in the bench:
- the exact period lengths and duty for each code, including the reserved codes;
- the count of two edges inside the busy window, and its exact length, in both slow-to-fast and fast-to-slow switches;
- the replacement of a pending code by a later write.

// File: rtl/presc_pkg.sv
package presc_pkg;

  // Phases of a ratio change
  typedef enum logic [1:0] {
    SW_IDLE   = 2'd0,  // no change pending
    SW_ARMED  = 2'd1,  // new ratio waiting for the next boundary
    SW_SETTLE = 2'd2   // first period at the new ratio is running
  } sw_state_t;

endpackage

// File: rtl/presc_counter.sv
module presc_counter #(
  parameter int MAX_LOG = 8,
  parameter int LOG_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LOG_W-1:0] log_sel,
  output logic             boundary,
  output logic             clk_out,
  output logic             clk_en
);

  localparam int CNT_W  = (MAX_LOG < 1) ? 1 : MAX_LOG;
  localparam int WIDE_W = CNT_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_inc;
  logic [CNT_W-1:0]  last;
  logic [CNT_W-1:0]  half;
  logic [WIDE_W-1:0] ratio;

  always_comb begin
    ratio   = WIDE_W'(1) << log_sel;
    last    = CNT_W'(ratio - WIDE_W'(1));
    half    = (log_sel == '0) ? CNT_W'(1) : CNT_W'(ratio >> 1);
    cnt_inc = cnt + 1'b1;
  end

  // The last source cycle of the divided period
  assign boundary = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      clk_out <= 1'b0;
      clk_en  <= 1'b0;
    end else if (boundary) begin
      cnt     <= '0;
      clk_out <= 1'b1;
      clk_en  <= 1'b1;
    end else begin
      cnt     <= cnt_inc;
      clk_out <= (cnt_inc < half);
      clk_en  <= 1'b0;
    end
  end

  // R6: the count stays inside the period of the active ratio
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);

  // R5: the enable pulse is never issued with the divided clock low
  p_en_high_r5: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> clk_out);

endmodule

// File: rtl/presc_switch_ctrl.sv
module presc_switch_ctrl
  import presc_pkg::*;
#(
  parameter int SEL_W   = 4,
  parameter int LOG_W   = 4,
  parameter int MAX_LOG = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             wr,
  input  logic             boundary,
  output logic [LOG_W-1:0] cur_log,
  output logic             busy
);

  sw_state_t        state;
  logic [LOG_W-1:0] pend_log;
  logic [LOG_W-1:0] sel_log;

  // R3: codes above the largest supported ratio fall back to divide-by-1
  always_comb begin
    if (int'(sel) > MAX_LOG) sel_log = '0;
    else                     sel_log = LOG_W'(sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SW_IDLE;
      cur_log  <= '0;
      pend_log <= '0;
      busy     <= 1'b0;
    end else if (wr) begin
      // A new write always re-arms and overrides anything pending
      pend_log <= sel_log;
      state    <= SW_ARMED;
      busy     <= 1'b1;
    end else if (boundary) begin
      case (state)
        SW_ARMED: begin
          cur_log <= pend_log;
          state   <= SW_SETTLE;
        end
        SW_SETTLE: begin
          state <= SW_IDLE;
          busy  <= 1'b0;
        end
        default: state <= SW_IDLE;
      endcase
    end
  end

  // R8: the flag is raised by every accepted write
  p_busy_rise_r8: assert property (@(posedge clk) disable iff (rst)
    wr |=> busy);

  // R6: the ratio moves only out of the armed phase
  p_apply_armed_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_log) |-> $past(state) == SW_ARMED);

endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler #(
  parameter int SEL_W   = 4,
  parameter int MAX_LOG = 8,
  parameter int LOG_W   = 4
) (
  input  logic             clk_src,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             div_wr,
  output logic             clk_out,
  output logic             clk_en,
  output logic             busy
);

  logic             boundary;
  logic [LOG_W-1:0] cur_log;

  presc_switch_ctrl #(
    .SEL_W  (SEL_W),
    .LOG_W  (LOG_W),
    .MAX_LOG(MAX_LOG)
  ) u_ctrl (
    .clk     (clk_src),
    .rst     (rst),
    .sel     (div_sel),
    .wr      (div_wr),
    .boundary(boundary),
    .cur_log (cur_log),
    .busy    (busy)
  );

  presc_counter #(
    .MAX_LOG(MAX_LOG),
    .LOG_W  (LOG_W)
  ) u_cnt (
    .clk     (clk_src),
    .rst     (rst),
    .log_sel (cur_log),
    .boundary(boundary),
    .clk_out (clk_out),
    .clk_en  (clk_en)
  );

  // R6: a ratio change coincides with the start of a period
  p_apply_on_edge_r6: assert property (@(posedge clk_src) disable iff (rst)
    !$stable(cur_log) |-> clk_en);

  // R5: every rising edge of the divided clock carries the enable
  p_rise_has_en_r5: assert property (@(posedge clk_src) disable iff (rst)
    $rose(clk_out) |-> clk_en);

  // R8: the flag clears only together with a divided rising edge
  p_busy_clear_r8: assert property (@(posedge clk_src) disable iff (rst)
    $fell(busy) |-> clk_en);

endmodule

// File: tb/test_sysclk_prescaler.sv
`timescale 1ns/1ps
module test_sysclk_prescaler;

  logic       clk_src = 1'b0;
  logic       rst     = 1'b1;
  logic [3:0] div_sel = '0;
  logic       div_wr  = 1'b0;
  logic       clk_out;
  logic       clk_en;
  logic       busy;

  int vectors     = 0;
  int miscompares = 0;
  bit finished    = 0;

  always #2.5 clk_src = ~clk_src;

  sysclk_prescaler i_sysclk_prescaler (
    .clk_src(clk_src),
    .rst    (rst),
    .div_sel(div_sel),
    .div_wr (div_wr),
    .clk_out(clk_out),
    .clk_en (clk_en),
    .busy   (busy)
  );

  function automatic int ratio_of(input int code);
    return (code <= 8) ? (1 << code) : 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called just after a sample with clk_en high; returns the period and high-phase length
  task automatic get_period(output int n, output int hi);
    n  = 0;
    hi = clk_out;
    forever begin
      @(negedge clk_src);
      n++;
      if (clk_en) break;
      hi += clk_out;
    end
  endtask

  task automatic wait_en();
    do @(negedge clk_src); while (!clk_en);
  endtask

  task automatic write_code(input int code);
    @(negedge clk_src);
    div_sel = 4'(code);
    div_wr  = 1'b1;
    @(negedge clk_src);
    div_wr  = 1'b0;
    chk("R8 busy after write", busy, 1);
  endtask

  task automatic settle(input int code);
    write_code(code);
    while (busy) @(negedge clk_src);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_src);
    chk("R1 clk_out in reset", clk_out, 0);
    chk("R1 clk_en in reset", clk_en, 0);
    chk("R1 busy in reset", busy, 0);
    rst = 1'b0;
    wait_en();
    begin
      int n, hi;
      get_period(n, hi);
      chk("R1 ratio after reset", n, 1);
    end
  endtask

  task automatic t_ratio(input int code, input string req);
    int n, hi;
    settle(code);
    get_period(n, hi);
    chk({req, " period"}, n, ratio_of(code));
    get_period(n, hi);
    chk({req, " second period"}, n, ratio_of(code));
    chk("R4 high phase", hi, (ratio_of(code) > 1) ? ratio_of(code) / 2 : 1);
    chk("R5 clk_out at enable", clk_out, 1);
  endtask

  // from_code must give a ratio of at least 4
  task automatic t_switch(input int from_code, input int to_code);
    int n, hi, pulses, samples, t1, t2;
    t1 = ratio_of(from_code);
    t2 = ratio_of(to_code);
    settle(from_code);
    get_period(n, hi);
    // at a clk_en sample: write lands on the second cycle of the period
    write_code(to_code);
    pulses  = clk_en;
    samples = 1;
    while (busy) begin
      @(negedge clk_src);
      samples++;
      pulses += clk_en;
    end
    chk("R8 edges in busy window", pulses, 2);
    chk("R6 R7 busy window length", samples, (t1 - 1) + t2);
    get_period(n, hi);
    chk("R7 period after switch", n, t2);
  endtask

  task automatic t_replace();
    int n, hi;
    settle(3);
    get_period(n, hi);
    write_code(6);
    write_code(2);
    while (busy) @(negedge clk_src);
    get_period(n, hi);
    chk("R9 last write wins", n, 4);
    get_period(n, hi);
    chk("R9 last write steady", n, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk_src);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    t_reset();
    for (int c = 0; c <= 8; c++) t_ratio(c, "R2");
    t_ratio(9, "R3");
    t_ratio(15, "R3");
    t_switch(4, 1);   // slow to fast
    t_switch(2, 7);   // fast to slow
    t_switch(8, 0);   // slowest to undivided
    t_replace();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule